// File: doc/BRIEF.md
# Reconfigurable Hard-Decision Viterbi Decoder

This block decodes a rate 1/2 convolutional code. The receiver supplies one pair of hard code bits per cycle, and the block returns the decoded data bits. The constraint length is chosen for each packet from 5, 7 or 9, and the same hardware serves all three. Every trellis state gets a new path metric in the same cycle from its two predecessors. States above the active count for the current packet are left untouched.

Survivor paths are held by register exchange. Each state keeps its whole decoded history, so there is no traceback pass. When a state's history reaches its depth, the oldest bit of the best state is sent out at every step. A flush pulse ends the packet. The decoder then runs K−1 internal steps that allow only zero inputs, which folds every path into state 0. It then reads out the rest of state 0's history, oldest bit first.

Top module: `vd_decoder`

## Requirements
- R1: Generators in octal, first/second: K=5 23/35, K=7 171/133, K=9 561/753. The coder register is {newest input, state}, and the generator MSB taps the newest input. in_pair[1] carries the first generator's bit. The branch metric is the Hamming distance (0..2).
- R2: The constraint length is sampled from in_k when in_valid and in_sop are both high (0=K5, 1=K7, 2 or 3=K9). At that step, state 0 starts from metric 0 and all other states from a large value.
- R3: An error-free coded packet with no tail bits decodes to exactly the sent data bits.
- R4: A packet with one flipped code bit well inside it still decodes to exactly the sent data bits.
- R5: The survivor depth is 5·K. When pairs arrive back to back, data bit i is on out_valid/out_bit in the cycle after the clock edge that accepts pair i+5·K.
- R6: in_flush is acted on only when in_valid is low. It starts K−1 zero-forced steps. The remaining bits then leave on consecutive cycles, starting K edges after the flush edge, so the total number of output bits equals the number of pairs.
- R7: When the two candidates in a compare are equal, the lower-numbered predecessor wins. A K=5 packet with the single pair 01 or 10 therefore decodes to one bit of value 0.
- R8: After every step, metrics are normalised by the previous minimum. The smallest active metric stays at or below 2, so packets of several hundred pairs decode without overflow.
- R9: Metrics and survivors of states at or above 2^(K−1) are not updated. A K=5 packet that follows a K=9 packet decodes the same as one that follows reset.
- R10: During and after reset, out_valid stays low until decoded bits are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received pair is present |
| in_sop | input | 1 | First pair of a packet; samples in_k |
| in_k | input | 2 | Constraint length code |
| in_pair | input | 2 | Hard received code bits |
| in_flush | input | 1 | End of packet; starts the tail and the readout |
| out_valid | output | 1 | out_bit holds a decoded bit |
| out_bit | output | 1 | Decoded data bit |

## Verification
Each result has a fixed due cycle. A mid-stream bit is due one cycle after the edge that accepts pair i+5K. The first bit left after a flush is due K edges after the flush edge, and the rest follow on consecutive cycles. The bench counts rising edges and samples outputs on falling edges. For each packet it records the edges at which the first pair and the flush were accepted. It then compares the edges of the first and last output bits against those offsets, and not only the values and the bit count.

// File: rtl/vd_pkg.sv
package vd_pkg;
   localparam int KMAX  = 9;
   localparam int SW    = KMAX - 1;
   localparam int NSMAX = 1 << SW;

   function automatic int k_len(input logic [1:0] sel);
      case (sel)
         2'd0:    return 5;
         2'd1:    return 7;
         default: return 9;
      endcase
   endfunction

   function automatic logic [KMAX-1:0] gen_a(input logic [1:0] sel);
      case (sel)
         2'd0:    return 9'o023;
         2'd1:    return 9'o171;
         default: return 9'o561;
      endcase
   endfunction

   function automatic logic [KMAX-1:0] gen_b(input logic [1:0] sel);
      case (sel)
         2'd0:    return 9'o035;
         2'd1:    return 9'o133;
         default: return 9'o753;
      endcase
   endfunction
endpackage

// File: rtl/vd_acs.sv
module vd_acs
   import vd_pkg::*;
#(
   parameter int IDX = 0,
   parameter int MW  = 8,
   parameter logic [MW-1:0] PM_FAR = '1
)(
   input  logic [1:0]    ksel,
   input  logic          tail,
   input  logic [1:0]    rx,
   input  logic [MW-1:0] pm_a,
   input  logic [MW-1:0] pm_b,
   output logic [MW-1:0] pm_new,
   output logic          dec,
   output logic          ubit
);
   int              kk;
   logic [KMAX-1:0] ra, rb, ga, gb;
   logic [1:0]      bma, bmb;
   logic [MW:0]     sa, sb;

   always_comb begin
      kk   = k_len(ksel);
      ga   = gen_a(ksel);
      gb   = gen_b(ksel);
      ra   = KMAX'((IDX * 2) & ((1 << kk) - 1));
      rb   = ra | KMAX'(1);
      ubit = 1'((IDX >> (kk - 2)) & 1);
      bma  = {1'b0, rx[1] ^ (^(ra & ga))} + {1'b0, rx[0] ^ (^(ra & gb))};
      bmb  = {1'b0, rx[1] ^ (^(rb & ga))} + {1'b0, rx[0] ^ (^(rb & gb))};
      if (tail) begin
         bma = '0;
         bmb = '0;
      end
      sa  = {1'b0, pm_a} + {{(MW-1){1'b0}}, bma};
      sb  = {1'b0, pm_b} + {{(MW-1){1'b0}}, bmb};
      dec = (sb < sa);
      if (tail && ubit) pm_new = PM_FAR;
      else              pm_new = dec ? sb[MW-1:0] : sa[MW-1:0];
   end
endmodule

// File: rtl/vd_best.sv
module vd_best #(
   parameter int MW = 8,
   parameter int SW = 8,
   parameter int NS = 1 << SW
)(
   input  logic [MW-1:0] pm [NS],
   input  logic [SW:0]   nact,
   output logic [SW-1:0] idx,
   output logic [MW-1:0] val
);
   always_comb begin
      idx = '0;
      val = pm[0];
      for (int i = 1; i < NS; i++) begin
         if (((SW+1)'(i) < nact) && (pm[i] < val)) begin
            val = pm[i];
            idx = SW'(i);
         end
      end
   end
endmodule

// File: rtl/vd_surv.sv
module vd_surv #(
   parameter int SW = 8,
   parameter int NS = 1 << SW,
   parameter int DW = 45,
   localparam int IW = $clog2(DW)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] en,
   input  logic [SW-1:0] pred [NS],
   input  logic [NS-1:0] ubit,
   input  logic          append,
   input  logic [SW-1:0] rd_state,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_bit
);
   logic [DW-1:0] sp_q [NS];

   for (genvar g = 0; g < NS; g++) begin : g_path
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sp_q[g] <= '0;
         else if (en[g]) sp_q[g] <= append ? {sp_q[pred[g]][DW-2:0], ubit[g]}
                                           : sp_q[pred[g]];
      end
   end

   assign rd_bit = sp_q[rd_state][rd_idx];
endmodule

// File: rtl/vd_decoder.sv
module vd_decoder
   import vd_pkg::*;
#(
   parameter int MW   = 8,
   parameter int DMUL = 5
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sop,
   input  logic [1:0] in_k,
   input  logic [1:0] in_pair,
   input  logic       in_flush,
   output logic       out_valid,
   output logic       out_bit
);
   localparam int DMAX = DMUL * KMAX;
   localparam int FW   = $clog2(DMAX + 1);
   localparam int IW   = $clog2(DMAX);
   localparam logic [MW-1:0] PM_FAR = MW'(1) << (MW - 2);

   if (MW < 8)   begin : g_bad_mw   $error("metric width below 8"); end
   if (DMUL < 4) begin : g_bad_dmul $error("survivor depth multiplier below 4"); end

   typedef enum logic [1:0] {S_RUN, S_TAIL, S_DRAIN} st_e;
   st_e           st_q;
   logic [1:0]    kq, k_eff;
   logic [FW-1:0] fill_q, fill_old, dk;
   logic [3:0]    tail_q;
   logic [MW-1:0] pm_q   [NSMAX];
   logic [MW-1:0] pm_old [NSMAX];
   logic [MW-1:0] pm_new [NSMAX];
   logic [SW-1:0] pred   [NSMAX];
   logic [NSMAX-1:0] dec, ubit, act, en;
   logic [SW:0]   nact;
   logic [SW-1:0] mask, best_idx, rd_state;
   logic [MW-1:0] best_val;
   logic [IW-1:0] rd_idx;
   logic          step_data, sop_now, tail_now, do_step, emit_data, emit_drain, rd_bit;
   int            kk;

   always_comb begin
      step_data  = (st_q == S_RUN) && in_valid;
      sop_now    = step_data && in_sop;
      tail_now   = (st_q == S_TAIL);
      do_step    = step_data || tail_now;
      k_eff      = sop_now ? in_k : kq;
      kk         = k_len(k_eff);
      nact       = (SW+1)'(1) << (kk - 1);
      mask       = SW'(nact - 1'b1);
      dk         = FW'(DMUL * kk);
      fill_old   = sop_now ? '0 : fill_q;
      emit_data  = step_data && (fill_old == dk);
      emit_drain = (st_q == S_DRAIN) && (fill_q != '0);
      rd_state   = (st_q == S_DRAIN) ? '0 : best_idx;
      rd_idx     = (st_q == S_DRAIN) ? IW'(fill_q - 1'b1) : IW'(dk - 1'b1);
   end

   for (genvar g = 0; g < NSMAX; g++) begin : g_state
      localparam logic [SW-1:0] P0 = SW'(2 * g);
      localparam logic [MW-1:0] PM_START = (g == 0) ? '0 : PM_FAR;
      logic [SW-1:0] p0;
      assign p0        = P0 & mask;
      assign pm_old[g] = sop_now ? PM_START : pm_q[g];
      assign act[g]    = ((SW+1)'(g) < nact);
      assign en[g]     = do_step && act[g];
      assign pred[g]   = p0 | SW'(dec[g]);

      vd_acs #(.IDX(g), .MW(MW), .PM_FAR(PM_FAR)) u_acs (
         .ksel(k_eff), .tail(tail_now), .rx(in_pair),
         .pm_a(pm_old[p0]), .pm_b(pm_old[p0 | SW'(1)]),
         .pm_new(pm_new[g]), .dec(dec[g]), .ubit(ubit[g]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pm_q[g] <= '0;
         else if (en[g]) pm_q[g] <= pm_new[g] - best_val;
      end

      // R9: a state outside the active range keeps its metric
      p_inactive_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (do_step && !act[g]) |=> $stable(pm_q[g]));
   end

   vd_best #(.MW(MW), .SW(SW), .NS(NSMAX)) u_best (
      .pm(pm_old), .nact(nact), .idx(best_idx), .val(best_val));

   vd_surv #(.SW(SW), .NS(NSMAX), .DW(DMAX)) u_surv (
      .clk(clk), .rst_n(rst_n), .en(en), .pred(pred), .ubit(ubit),
      .append(step_data), .rd_state(rd_state), .rd_idx(rd_idx), .rd_bit(rd_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_RUN;
         kq        <= '0;
         fill_q    <= '0;
         tail_q    <= '0;
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= emit_data || emit_drain;
         if (emit_data || emit_drain) out_bit <= rd_bit;
         case (st_q)
            S_RUN: begin
               if (step_data) begin
                  kq     <= k_eff;
                  fill_q <= emit_data ? dk : fill_old + 1'b1;
               end else if (in_flush) begin
                  st_q   <= S_TAIL;
                  tail_q <= 4'(kk - 1);
               end
            end
            S_TAIL: begin
               tail_q <= tail_q - 1'b1;
               if (tail_q == 4'd1) st_q <= S_DRAIN;
            end
            default: begin
               if (fill_q != '0) fill_q <= fill_q - 1'b1;
               if (fill_q <= FW'(1)) st_q <= S_RUN;
            end
         endcase
      end
   end

   p_metric_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      do_step |=> (best_val <= MW'(2)));
   p_sop_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sop_now |=> (pm_q[0] <= MW'(2)));
   p_emit_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(step_data || (st_q == S_DRAIN)));
   p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q <= FW'(DMUL * k_len(kq))));
   p_quiet_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_TAIL) |-> !out_valid);
endmodule

// File: tb/vd_decoder_tb.sv
module vd_decoder_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_flush = 1'b0;
   logic [1:0] in_k = 2'd0, in_pair = 2'd0;
   logic       out_valid, out_bit;

   always #10 clk = ~clk;

   vd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_k(in_k), .in_pair(in_pair), .in_flush(in_flush),
      .out_valid(out_valid), .out_bit(out_bit));

   int   cyc = 0;
   int   n_chk = 0, n_fail = 0;
   int   rx_cnt = 0, first_cyc = 0, last_cyc = 0;
   logic rx_bits [0:511];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rx_cnt == 0) first_cyc = cyc;
         last_cyc = cyc;
         if (rx_cnt < 512) rx_bits[rx_cnt] = out_bit;
         rx_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int k_of(input int code);
      return (code == 0) ? 5 : (code == 1) ? 7 : 9;
   endfunction

   function automatic int ga_of(input int k);
      return (k == 5) ? 'o23 : (k == 7) ? 'o171 : 'o561;
   endfunction

   function automatic int gb_of(input int k);
      return (k == 5) ? 'o35 : (k == 7) ? 'o133 : 'o753;
   endfunction

   localparam int NV = 7;
   localparam int T_K    [NV] = '{0, 1, 2, 0, 2, 0, 1};
   localparam int T_LEN  [NV] = '{60, 80, 120, 20, 200, 40, 10};
   localparam int T_ERR  [NV] = '{-1, 30, 50, -1, 100, 15, -1};
   localparam int T_SEED [NV] = '{'hACE1, 'h1234, 'hBEEF, 'h0F0F, 'h5A5A, 'hBEEF, 'h7777};

   initial begin
      logic bad;
      bad = 1'b0;
      repeat (3) @(negedge clk);
      if (out_valid !== 1'b0) bad = 1'b1;
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         if (out_valid !== 1'b0) bad = 1'b1;
      end
      check(!bad, "R10 out_valid low around reset", int'(bad), 0);

      for (int v = 0; v < NV; v++) begin
         int k, len, dk, c0, cf, errs, sr, a, b, r;
         logic [15:0] lfsr;
         logic d [0:511];
         logic [1:0] pr;
         string tag;
         k    = k_of(T_K[v]);
         len  = T_LEN[v];
         dk   = 5 * k;
         lfsr = 16'(T_SEED[v]);
         sr   = 0;
         c0   = 0;
         rx_cnt = 0;
         for (int j = 0; j < len; j++) begin
            d[j] = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r    = (int'(d[j]) << (k - 1)) | sr;
            a    = $countones(r & ga_of(k)) & 1;
            b    = $countones(r & gb_of(k)) & 1;
            sr   = r >> 1;
            pr   = {a[0], b[0]};
            if (j == T_ERR[v]) pr[1] = ~pr[1];
            @(negedge clk);
            if (j == 0) c0 = cyc;
            in_valid = 1'b1;
            in_sop   = (j == 0);
            in_k     = 2'(T_K[v]);
            in_pair  = pr;
         end
         @(negedge clk);
         in_valid = 1'b0;
         in_sop   = 1'b0;
         in_flush = 1'b1;
         cf = cyc;
         @(negedge clk);
         in_flush = 1'b0;
         for (int w = 0; w < 400 && rx_cnt < len; w++) @(negedge clk);
         repeat (20) @(negedge clk);

         errs = 0;
         for (int j = 0; j < len && j < 512; j++) if (rx_bits[j] !== d[j]) errs++;
         if (v == 1)           tag = "R2 K change at packet start";
         else if (v == 4)      tag = "R8 long packet data";
         else if (v == 5)      tag = "R9 K5 after K9 data";
         else if (T_ERR[v] < 0) tag = "R1/R3 error-free data";
         else                  tag = "R4 single error corrected";
         check(errs == 0, tag, errs, 0);
         check(rx_cnt == len, "R6 output bit count", rx_cnt, len);
         if (len > dk) begin
            check(first_cyc - (c0 + 1) == dk, "R5 first bit latency", first_cyc - (c0 + 1), dk);
         end else begin
            check(first_cyc == cf + 1 + k, "R6 drain start", first_cyc - cf - 1, k);
            check(last_cyc - first_cyc + 1 == len, "R6 drain consecutive", last_cyc - first_cyc + 1, len);
         end
      end

      for (int t = 0; t < 2; t++) begin
         rx_cnt = 0;
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = 1'b1;
         in_k     = 2'd0;
         in_pair  = (t == 0) ? 2'b01 : 2'b10;
         @(negedge clk);
         in_valid = 1'b0;
         in_sop   = 1'b0;
         in_flush = 1'b1;
         @(negedge clk);
         in_flush = 1'b0;
         repeat (30) @(negedge clk);
         check(rx_cnt == 1, "R7 tie packet count", rx_cnt, 1);
         check(rx_bits[0] === 1'b0, "R7 tie picks upper branch", int'(rx_bits[0]), 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule